// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter with Load and Modulus Option

The block is a chain of 4-bit synchronous up-counter stages. Each stage can be cleared, loaded from a data input, or advanced by one. It advances only when two enables are both high. One enable, `ent`, also gates that stage's carry to the stage above. Every action takes place on the rising edge of `clk`. The order of precedence is fixed: clear first, then load, then count, then hold. Stages are joined by feeding each carry into the `ent` of the next stage, while `enp` goes to every stage. An upper nibble therefore steps only when every nibble below it sits at its terminal value.

A static parameter can shorten the lowest stage's sequence by feeding its terminal-count detect back into one of its own paths. In load mode, a count of 15 makes the stage reload 5, so it runs 5 to 15. In clear mode, a count of 10 makes the stage clear, so it runs 0 to 10. In both modes the stage passes its carry upward at that terminal value. An optional registered one-hot decode of the lowest nibble gives state strobes that cannot glitch, one clock behind the count.

Top module: `casc_counter`

## Requirements
- R1: A high `clr` or `rst` at a rising edge sets `q` to zero, whatever the values of `ld`, `enp` and `ent`.
- R2: When `clr` and `rst` are low and `ld` is high, the next edge copies `din` into `q`, whatever the enables are.
- R3: When no clear or load is active, `q` increases by one only if `enp` and `ent` are both high. Otherwise `q` holds.
- R4: A stage's carry is high exactly when its `ent` is high and its nibble equals 15, independent of `enp`. The nibble above steps only at such a carry.
- R5: In free mode, `rco` is high exactly when `ent` is high and all bits of `q` are 1, independent of `enp`.
- R6: In free mode, the chain runs through 2^(4*STAGES) states and wraps from all ones to zero.
- R7: In load mode (MODE=CM_LOAD), an enabled count at lowest nibble 15 loads 5 instead. The nibble repeats 5..15, and the stage carry is high at 15 whenever `ent` is high. While the stage is not enabled, it holds at 15.
- R8: In clear mode (MODE=CM_CLEAR), an enabled count at lowest nibble 10 clears it. The nibble repeats 0..10, and the stage carry is high at 10 whenever `ent` is high. An external `ld` takes precedence over this feedback clear.
- R9: `dec` is zero after a reset edge. After any other edge, `dec` has exactly one bit set: bit k, where k was the lowest nibble of `q` before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, acts as a clear |
| clr | input | 1 | Synchronous clear, highest precedence |
| ld | input | 1 | Synchronous parallel load |
| enp | input | 1 | Count enable shared by all stages |
| ent | input | 1 | Count enable that also qualifies the carry chain |
| din | input | 4*STAGES | Parallel load data |
| q | output | 4*STAGES | Current count |
| rco | output | 1 | Carry out of the top stage, for a further cascade |
| dec | output | 16 | Registered one-hot decode of the lowest nibble |

## Verification
A two-stage free-running chain is driven with a sequence of rows, each with its own control pattern. The rows separate each enable acting alone from both together, load with the enables off from load with the enables on, and all four controls high at once, which must yield zero. The rows hold the count at all ones with each enable high in turn, which shows that `rco` follows `ent` and ignores `enp`. A load of 0x7F followed by one count shows the carry crossing into the upper nibble. Single-stage load-mode and clear-mode instances are then run from a common start value through several full loops, checking the count, the terminal carry and the delayed decode on every edge, plus a hold at the terminal value.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    CM_FREE  = 2'd0,
    CM_LOAD  = 2'd1,
    CM_CLEAR = 2'd2
  } cnt_mode_e;

  localparam int MOD_LOAD_START = 5;
  localparam int MOD_CLEAR_TERM = 10;
endpackage

// File: rtl/cnt_stage.sv
module cnt_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic         enp,
  input  logic         ent,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rco
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst || clr)      q_r <= '0;
    else if (ld)         q_r <= d;
    else if (enp && ent) q_r <= q_r + 1'b1;
  end

  assign q   = q_r;
  assign rco = ent && (q_r == MAXV);

  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0);
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && ld) |=> q == $past(d));
  assert_count_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld && enp && ent) |=> q == W'($past(q) + 1'b1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld && !(enp && ent)) |=> $stable(q));
  assert_carry_R4: assert property (@(posedge clk) disable iff (rst)
    rco |-> (ent && !$isunknown(q)));
endmodule

// File: rtl/cnt_decode.sv
module cnt_decode #(
  parameter int W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      val,
  output logic [(1<<W)-1:0] dec
);
  localparam int DW = 1 << W;

  logic [DW-1:0] dec_r;

  always_ff @(posedge clk) begin
    if (rst) dec_r <= '0;
    else     dec_r <= DW'(1) << val;
  end

  assign dec = dec_r;

  assert_dec_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $onehot(dec));
  assert_dec_lag_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> dec[$past(val)]);
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int        STAGES    = 2,
  parameter int        NIB_W     = 4,
  parameter cnt_mode_e MODE      = CM_FREE,
  parameter bit        DECODE_EN = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      ld,
  input  logic                      enp,
  input  logic                      ent,
  input  logic [STAGES*NIB_W-1:0]   din,
  output logic [STAGES*NIB_W-1:0]   q,
  output logic                      rco,
  output logic [(1<<NIB_W)-1:0]     dec
);
  localparam int             TOT_W     = STAGES * NIB_W;
  localparam logic [NIB_W-1:0] ALL_ONES  = {NIB_W{1'b1}};
  localparam logic [NIB_W-1:0] LD_START  = NIB_W'(MOD_LOAD_START);
  localparam logic [NIB_W-1:0] CLR_TERM  = NIB_W'(MOD_CLEAR_TERM);

  logic [STAGES:0] carry;
  logic [STAGES-1:0] st_rco;
  logic [NIB_W-1:0] q_lo;
  logic fb_ld, fb_clr;
  logic [NIB_W-1:0] d_lo;

  assign carry[0] = ent;
  assign q_lo     = q[NIB_W-1:0];

  generate
    if (MODE == CM_LOAD) begin : g_fb_load
      assign fb_ld  = enp && ent && (q_lo == ALL_ONES);
      assign fb_clr = 1'b0;
    end else if (MODE == CM_CLEAR) begin : g_fb_clear
      assign fb_ld  = 1'b0;
      assign fb_clr = enp && ent && !ld && (q_lo == CLR_TERM);
    end else begin : g_fb_none
      assign fb_ld  = 1'b0;
      assign fb_clr = 1'b0;
    end
  endgenerate

  assign d_lo = ld ? din[NIB_W-1:0] : LD_START;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_low
        cnt_stage #(.W(NIB_W)) u_stage (
          .clk (clk),
          .rst (rst),
          .clr (clr || fb_clr),
          .ld  (ld || fb_ld),
          .enp (enp),
          .ent (carry[0]),
          .d   (d_lo),
          .q   (q[NIB_W-1:0]),
          .rco (st_rco[0])
        );
        if (MODE == CM_CLEAR) begin : g_term10
          assign carry[1] = carry[0] && (q_lo == CLR_TERM);
        end else begin : g_term15
          assign carry[1] = st_rco[0];
        end
      end else begin : g_high
        cnt_stage #(.W(NIB_W)) u_stage (
          .clk (clk),
          .rst (rst),
          .clr (clr),
          .ld  (ld),
          .enp (enp),
          .ent (carry[i]),
          .d   (din[i*NIB_W +: NIB_W]),
          .q   (q[i*NIB_W +: NIB_W]),
          .rco (st_rco[i])
        );
        assign carry[i+1] = st_rco[i];
      end
    end
  endgenerate

  assign rco = carry[STAGES];

  generate
    if (DECODE_EN) begin : g_dec
      cnt_decode #(.W(NIB_W)) u_dec (
        .clk (clk),
        .rst (rst),
        .val (q_lo),
        .dec (dec)
      );
    end else begin : g_nodec
      assign dec = '0;
    end
  endgenerate

  assert_rco_ent_R5: assert property (@(posedge clk) disable iff (rst)
    rco |-> ent);

  generate
    if (MODE == CM_FREE) begin : g_chk_free
      assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ld && enp && ent && q == {TOT_W{1'b1}}) |=> q == '0);
    end
    if (MODE == CM_LOAD) begin : g_chk_load
      assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ld && enp && ent && q_lo == ALL_ONES) |=> q_lo == LD_START);
    end
    if (MODE == CM_CLEAR) begin : g_chk_clear
      assert_modclr_R8: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ld && enp && ent && q_lo == CLR_TERM) |=> q_lo == '0);
    end
  endgenerate
endmodule

// File: tb/casc_counter_bench.sv
`timescale 1ns/1ps
module casc_counter_bench;
  import cnt_pkg::*;

  logic clk = 1'b0;
  logic rst, clr, ld, enp, ent;
  logic [7:0] din;
  logic [7:0] q;
  logic [3:0] q_ld, q_cl;
  logic rco, rco_ld, rco_cl;
  logic [15:0] dec, dec_ld, dec_cl;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  casc_counter #(.STAGES(2), .MODE(CM_FREE)) u_casc_counter (
    .clk(clk), .rst(rst), .clr(clr), .ld(ld), .enp(enp), .ent(ent),
    .din(din), .q(q), .rco(rco), .dec(dec));

  casc_counter #(.STAGES(1), .MODE(CM_LOAD)) u_casc_counter_ld (
    .clk(clk), .rst(rst), .clr(clr), .ld(ld), .enp(enp), .ent(ent),
    .din(din[3:0]), .q(q_ld), .rco(rco_ld), .dec(dec_ld));

  casc_counter #(.STAGES(1), .MODE(CM_CLEAR)) u_casc_counter_cl (
    .clk(clk), .rst(rst), .clr(clr), .ld(ld), .enp(enp), .ent(ent),
    .din(din[3:0]), .q(q_cl), .rco(rco_cl), .dec(dec_cl));

  // row: {clr, ld, enp, ent, din[7:0], exp_q[7:0], exp_rco}
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {4'b0111, 8'h0E, 8'h0E, 1'b0},
    {4'b0011, 8'h00, 8'h0F, 1'b0},
    {4'b0011, 8'h00, 8'h10, 1'b0},
    {4'b0001, 8'h00, 8'h10, 1'b0},
    {4'b0010, 8'h00, 8'h10, 1'b0},
    {4'b0100, 8'hFE, 8'hFE, 1'b0},
    {4'b0011, 8'h00, 8'hFF, 1'b1},
    {4'b0001, 8'h00, 8'hFF, 1'b1},
    {4'b0010, 8'h00, 8'hFF, 1'b0},
    {4'b0011, 8'h00, 8'h00, 1'b0},
    {4'b0111, 8'h3C, 8'h3C, 1'b0},
    {4'b1111, 8'h55, 8'h00, 1'b0},
    {4'b0111, 8'h7F, 8'h7F, 1'b0},
    {4'b0011, 8'h00, 8'h80, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] m_ld, m_cl, prev_ld, prev_cl;
    rst = 1'b1; clr = 1'b0; ld = 1'b0; enp = 1'b1; ent = 1'b1; din = 8'h00;
    @(negedge clk);
    tick(); tick();
    check("R1 reset q", 32'(q), 32'h0);
    check("R9 reset dec", 32'(dec), 32'h0);
    check("R5 reset rco", 32'(rco), 32'h0);
    rst = 1'b0;

    // vector walk: R1 R2 R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      {clr, ld, enp, ent, din} = VEC[k][20:9];
      tick();
      check($sformatf("R1 R2 R3 R4 R6 row %0d q", k), 32'(q), 32'(VEC[k][8:1]));
      check($sformatf("R4 R5 row %0d rco", k), 32'(rco), 32'(VEC[k][0]));
    end

    // R9 decode lags the low nibble by one edge
    clr = 1'b0; ld = 1'b0; enp = 1'b1; ent = 1'b1;
    tick();
    check("R9 dec after 0x80->0x81", 32'(dec), 32'h0001);

    // modulus modes from a common start of 9
    ld = 1'b1; din = 8'h09;
    tick();
    ld = 1'b0;
    check("R7 start", 32'(q_ld), 32'h9);
    check("R8 start", 32'(q_cl), 32'h9);
    m_ld = 4'h9; m_cl = 4'h9;
    for (int s = 0; s < 30; s++) begin
      prev_ld = m_ld; prev_cl = m_cl;
      m_ld = (m_ld == 4'hF) ? 4'h5 : m_ld + 4'h1;
      m_cl = (m_cl == 4'hA) ? 4'h0 : m_cl + 4'h1;
      tick();
      check($sformatf("R7 step %0d q", s), 32'(q_ld), 32'(m_ld));
      check($sformatf("R7 step %0d carry", s), 32'(rco_ld), 32'(m_ld == 4'hF));
      check($sformatf("R8 step %0d q", s), 32'(q_cl), 32'(m_cl));
      check($sformatf("R8 step %0d carry", s), 32'(rco_cl), 32'(m_cl == 4'hA));
      check($sformatf("R9 step %0d dec", s), 32'(dec_ld), 32'(16'(1) << prev_ld));
      check($sformatf("R9 step %0d dec clr", s), 32'(dec_cl), 32'(16'(1) << prev_cl));
    end

    // R7 hold at terminal while enp low
    ld = 1'b1; din = 8'h0F;
    tick();
    ld = 1'b0; enp = 1'b0;
    tick();
    check("R7 hold at 15", 32'(q_ld), 32'hF);
    check("R7 carry at hold", 32'(rco_ld), 32'h1);

    // R8 external load beats feedback clear at 10
    enp = 1'b1; ld = 1'b1; din = 8'h0A;
    tick();
    din = 8'h03;
    tick();
    ld = 1'b0;
    check("R8 load over feedback clear", 32'(q_cl), 32'h3);

    // R1 reset beats load
    rst = 1'b1; ld = 1'b1; din = 8'hAA;
    tick();
    check("R1 reset over load", 32'(q), 32'h0);
    check("R9 dec zero in reset", 32'(dec), 32'h0);
    rst = 1'b0; ld = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule